// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares IEEE-754 single-precision values and stores the one-bit outcome in a condition-code field of a 32-bit floating-point status word. A 4-bit predicate code picks one of sixteen tests. The tests cover equality, less-than and less-or-equal, and each test has a variant that is true on unordered inputs. A 3-bit index picks which of the eight condition codes receives the result.

In paired mode, each 64-bit operand carries two singles. The two lanes are compared independently and the results land in two adjacent condition codes. The unit also flags invalid operations, and it offers a combinational read port that returns a chosen code and its neighbour. Branch and conditional-move logic elsewhere in the pipeline uses that port.

A compare is launched by one cycle of `cmpValid`. The result is captured at that edge and committed to the status word at the next edge. Compares may be issued on back-to-back cycles.

Top module: `fcmp_cc_unit`

## Requirements
- R1: While reset is asserted and after it is released, `statusWord` is all zeros and `invalidOp` is 0.
- R2: A lane is unordered when either of its operands is a NaN, meaning exponent bits 30:23 are all ones and fraction bits 22:0 are nonzero. An unordered lane yields `predCode[0]`. Predicate encoding of `predCode[2:0]`: 0 false, 1 unordered, 2 equal, 3 unordered-or-equal, 4 less, 5 unordered-or-less, 6 less-or-equal, 7 unordered-or-less-or-equal. `predCode[3]` selects the signalling variant, which gives the same result as its quiet partner.
- R3: An ordered lane yields (`predCode[1]` AND a==b) OR (`predCode[2]` AND a<b). The comparison is numeric: +0 equals -0, and infinities order below or above all finite values.
- R4: Predicate codes 0 and 8 always produce 0, including on NaN inputs.
- R5: Condition code 0 is status bit 23, and condition code k (1..7) is status bit 24+k. A non-paired compare changes only the selected bit, and all other status bits keep their values.
- R6: In paired mode, the low 32 bits of the operands decide code `ccIdx` and the high 32 bits decide code (`ccIdx`+1) mod 8. In non-paired mode, the high 32 bits have no effect.
- R7: `invalidOp` pulses for one cycle, in the cycle after the valid strobe. If `predCode[3]` is 1, it is raised when any compared operand is a NaN. If `predCode[3]` is 0, it is raised only for a signalling NaN, meaning fraction bit 22 is 0. In paired mode, both lanes count.
- R8: The status word still holds its old value in the cycle after the strobe and shows the new value one cycle later. Strobes on consecutive cycles are all committed.
- R9: `ccRdLo` returns condition code `ccRdIdx`, and `ccRdHi` returns code (`ccRdIdx`+1) mod 8, both read from the current status word.
- R10: Without a valid strobe, the status word does not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpValid | input | 1 | Launches a compare this cycle |
| opA | input | 64 | First operand; lane 0 in bits 31:0, lane 1 in bits 63:32 |
| opB | input | 64 | Second operand, same layout |
| predCode | input | 4 | Compare predicate |
| ccIdx | input | 3 | Destination condition code |
| pairMode | input | 1 | Compare both lanes and write two codes |
| ccRdIdx | input | 3 | Condition code to read |
| statusWord | output | 32 | Floating-point status word |
| invalidOp | output | 1 | Invalid-operation pulse |
| ccRdLo | output | 1 | Condition code `ccRdIdx` |
| ccRdHi | output | 1 | Condition code `ccRdIdx`+1 |

## Verification
The design has two internal stages, so a wrong captured result, index or pair flag shows up in `statusWord` two edges after the strobe. It appears either as a wrong bit at the expected position or as a change to a bit that should have been left alone. A fault in NaN classification shows up one edge earlier through `invalidOp`. Because every status bit persists, the bench compares the full word against a running model after every compare, so a corrupted bit left behind by an earlier compare is still caught by a later check. The read port is checked against the same model for every index, including the wrap from code 7 to code 0.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int EXP_W = 8;
  localparam int FRAC_W = 23;
  localparam int LANE_W = 1 + EXP_W + FRAC_W;
  localparam int LANES = 2;
  localparam int PRED_W = 4;
  localparam int CC_IDX_W = 3;
  localparam int STAT_W = 32;
  localparam int POS_W = $clog2(STAT_W);
  localparam logic [POS_W-1:0] CC0_POS = POS_W'(23);
  localparam logic [POS_W-1:0] CCN_BASE = POS_W'(24);

  typedef struct packed {
    logic capture;
    logic commit;
  } cmpStrobes_t;

  function automatic logic [POS_W-1:0] ccBitPos(input logic [CC_IDX_W-1:0] idx);
    if (idx == '0) return CC0_POS;
    return CCN_BASE + POS_W'(idx);
  endfunction
endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
(
  input  logic [LANE_W-1:0] aBits,
  input  logic [LANE_W-1:0] bBits,
  input  logic [PRED_W-1:0] pred,
  output logic              cond,
  output logic              inv
);
  logic signA, signB;
  logic [LANE_W-2:0] magA, magB;
  logic nanA, nanB, sNanA, sNanB, unord, bothZero, isEq, isLt;

  always_comb begin
    signA = aBits[LANE_W-1];
    signB = bBits[LANE_W-1];
    magA = aBits[LANE_W-2:0];
    magB = bBits[LANE_W-2:0];
    nanA = (&aBits[LANE_W-2:FRAC_W]) && (|aBits[FRAC_W-1:0]);
    nanB = (&bBits[LANE_W-2:FRAC_W]) && (|bBits[FRAC_W-1:0]);
    sNanA = nanA && !aBits[FRAC_W-1];
    sNanB = nanB && !bBits[FRAC_W-1];
    unord = nanA || nanB;
    bothZero = (magA == '0) && (magB == '0);
    isEq = bothZero || (aBits == bBits);
    if (bothZero) isLt = 1'b0;
    else if (signA != signB) isLt = signA;
    else if (!signA) isLt = magA < magB;
    else isLt = magA > magB;
    if (unord) cond = pred[0];
    else cond = (pred[1] && isEq) || (pred[2] && isLt);
    inv = pred[PRED_W-1] ? unord : (sNanA || sNanB);
  end

  always_comb begin
    if (!unord) AST_EQ_LT_EXCLUSIVE: assert (!(isEq && isLt)); // R3
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmpValid,
  output cmpStrobes_t strobes
);
  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else pendQ <= cmpValid;
  end

  always_comb begin
    strobes.capture = cmpValid;
    strobes.commit = pendQ;
  end

  AST_COMMIT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |=> strobes.commit); // R8
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  cmpStrobes_t             strobes,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  input  logic [PRED_W-1:0]       predCode,
  input  logic [CC_IDX_W-1:0]     ccIdx,
  input  logic                    pairMode,
  input  logic [CC_IDX_W-1:0]     ccRdIdx,
  output logic [STAT_W-1:0]       statusWord,
  output logic                    invalidOp,
  output logic                    ccRdLo,
  output logic                    ccRdHi
);
  logic [LANES-1:0] laneCond, laneInv;
  logic [LANES-1:0] condQ;
  logic [CC_IDX_W-1:0] idxQ;
  logic pairQ, invalidQ, invNext;
  logic [STAT_W-1:0] statusQ, statusNext;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    fcmp_lane uLane (
      .aBits(opA[l*LANE_W +: LANE_W]),
      .bBits(opB[l*LANE_W +: LANE_W]),
      .pred (predCode),
      .cond (laneCond[l]),
      .inv  (laneInv[l])
    );
  end

  always_comb invNext = laneInv[0] || (pairMode && (|laneInv[LANES-1:1]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ <= '0;
      idxQ <= '0;
      pairQ <= 1'b0;
      invalidQ <= 1'b0;
    end else begin
      invalidQ <= strobes.capture && invNext;
      if (strobes.capture) begin
        condQ <= laneCond;
        idxQ <= ccIdx;
        pairQ <= pairMode;
      end
    end
  end

  always_comb begin
    logic [CC_IDX_W-1:0] idxUp;
    idxUp = idxQ + 1'b1;
    statusNext = statusQ;
    statusNext[ccBitPos(idxQ)] = condQ[0];
    if (pairQ) statusNext[ccBitPos(idxUp)] = condQ[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else if (strobes.commit) statusQ <= statusNext;
  end

  always_comb begin
    logic [CC_IDX_W-1:0] rdUp;
    rdUp = ccRdIdx + 1'b1;
    ccRdLo = statusQ[ccBitPos(ccRdIdx)];
    ccRdHi = statusQ[ccBitPos(rdUp)];
  end

  assign statusWord = statusQ;
  assign invalidOp = invalidQ;

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(statusQ)); // R10
  AST_SINGLE_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !pairQ) |=> ($countones(statusQ ^ $past(statusQ)) <= 1)); // R5
  AST_PAIR_WRITE_TWO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> ($countones(statusQ ^ $past(statusQ)) <= 2)); // R6
  AST_INVALID_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> $past(strobes.capture)); // R7
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
  import fcmp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmpValid,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  input  logic [PRED_W-1:0]       predCode,
  input  logic [CC_IDX_W-1:0]     ccIdx,
  input  logic                    pairMode,
  input  logic [CC_IDX_W-1:0]     ccRdIdx,
  output logic [STAT_W-1:0]       statusWord,
  output logic                    invalidOp,
  output logic                    ccRdLo,
  output logic                    ccRdHi
);
  cmpStrobes_t strobes;

  fcmp_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmpValid(cmpValid),
    .strobes (strobes)
  );

  fcmp_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .predCode  (predCode),
    .ccIdx     (ccIdx),
    .pairMode  (pairMode),
    .ccRdIdx   (ccRdIdx),
    .statusWord(statusWord),
    .invalidOp (invalidOp),
    .ccRdLo    (ccRdLo),
    .ccRdHi    (ccRdHi)
  );
endmodule

// File: tb/test_fcmp_cc_unit.sv
`timescale 1ns/1ps
module test_fcmp_cc_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpValid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [3:0] predCode = '0;
  logic [2:0] ccIdx = '0, ccRdIdx = '0;
  logic pairMode = 1'b0;
  logic [31:0] statusWord;
  logic invalidOp, ccRdLo, ccRdHi;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] expSt = '0;

  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000, NEG1 = 32'hBF800000;
  localparam logic [31:0] NEG2 = 32'hC0000000, PZ = 32'h0, NZ = 32'h80000000;
  localparam logic [31:0] NINF = 32'hFF800000, QNAN = 32'h7FC00000, SNAN = 32'h7F800001;
  localparam logic [31:0] JUNK = 32'hDEADBEEF;

  // {pred, a, b, expected condition, expected invalid}
  localparam int NV = 18;
  localparam logic [69:0] VEC [NV] = '{
    {4'd2,  ONE,  ONE,  1'b1, 1'b0},  // R3 equal
    {4'd2,  ONE,  TWO,  1'b0, 1'b0},  // R3
    {4'd4,  ONE,  TWO,  1'b1, 1'b0},  // R3 less
    {4'd4,  TWO,  ONE,  1'b0, 1'b0},  // R3
    {4'd6,  TWO,  TWO,  1'b1, 1'b0},  // R3 less-or-equal
    {4'd4,  NEG1, ONE,  1'b1, 1'b0},  // R3 sign
    {4'd4,  NINF, NEG1, 1'b1, 1'b0},  // R3 infinity
    {4'd2,  PZ,   NZ,   1'b1, 1'b0},  // R3 signed zeros
    {4'd4,  NZ,   PZ,   1'b0, 1'b0},  // R3
    {4'd1,  QNAN, ONE,  1'b1, 1'b0},  // R2 unordered
    {4'd3,  ONE,  QNAN, 1'b1, 1'b0},  // R2
    {4'd2,  QNAN, QNAN, 1'b0, 1'b0},  // R2
    {4'd10, QNAN, ONE,  1'b0, 1'b1},  // R7 signalling group
    {4'd4,  SNAN, ONE,  1'b0, 1'b1},  // R7 signalling NaN
    {4'd0,  ONE,  ONE,  1'b0, 1'b0},  // R4
    {4'd8,  QNAN, ONE,  1'b0, 1'b1},  // R4
    {4'd15, ONE,  TWO,  1'b1, 1'b0},  // R2 twin
    {4'd4,  NEG2, NEG1, 1'b1, 1'b0}   // R3 both negative
  };

  i_fcmp_cc_unit_wrap: begin end
  fcmp_cc_unit i_fcmp_cc_unit (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .opA(opA), .opB(opB),
    .predCode(predCode), .ccIdx(ccIdx), .pairMode(pairMode), .ccRdIdx(ccRdIdx),
    .statusWord(statusWord), .invalidOp(invalidOp), .ccRdLo(ccRdLo), .ccRdHi(ccRdHi)
  );

  always #2.5 clk = ~clk;

  function automatic int posOf(input logic [2:0] i);
    return (i == 3'd0) ? 23 : 24 + int'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doCmp(input logic [3:0] p, input logic [63:0] a, input logic [63:0] b,
                       input logic [2:0] idx, input logic pr, input logic eLo,
                       input logic eHi, input logic eInv, input string tag);
    @(negedge clk);
    cmpValid = 1'b1; predCode = p; opA = a; opB = b; ccIdx = idx; pairMode = pr;
    @(negedge clk);
    cmpValid = 1'b0; opA = {JUNK, JUNK}; opB = '0;
    chk({tag, " invalidOp R7"}, 32'(invalidOp), 32'(eInv));
    chk({tag, " status not yet updated R8"}, statusWord, expSt);
    expSt[posOf(idx)] = eLo;
    if (pr) expSt[posOf(idx + 3'd1)] = eHi;
    @(negedge clk);
    chk({tag, " status R5"}, statusWord, expSt);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", statusWord, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", statusWord, 32'h0);
    chk("R1 invalidOp after reset", 32'(invalidOp), 32'h0);

    // Table walk; high lane carries junk to show it is ignored (R6)
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      doCmp(v[69:66], {JUNK, v[65:34]}, {~JUNK, v[33:2]}, 3'(i % 8), 1'b0,
            v[1], 1'b0, v[0], $sformatf("vec%0d R2/R3", i));
    end

    // R6 paired: low lane to code 3, high lane to code 4
    doCmp(4'd4, {TWO, ONE}, {ONE, TWO}, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R6 pair");
    doCmp(4'd4, {ONE, TWO}, {TWO, ONE}, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R6 pair swap");
    // R6 wrap: code 7 and code 0
    doCmp(4'd2, {ONE, ONE}, {ONE, ONE}, 3'd7, 1'b1, 1'b1, 1'b1, 1'b0, "R6 wrap set");
    doCmp(4'd2, {ONE, ONE}, {TWO, TWO}, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, "R6 wrap clear");
    // R7 invalid from high lane only in pair mode, and not in single mode
    doCmp(4'd2, {SNAN, ONE}, {ONE, ONE}, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, "R7 pair high sNaN");
    doCmp(4'd2, {SNAN, ONE}, {ONE, ONE}, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R7 single ignores high");
    doCmp(4'd5, {QNAN, ONE}, {ONE, QNAN}, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, "R7 quiet qNaN no flag");

    // R9 read port across all indices
    for (int k = 0; k < 8; k++) begin
      ccRdIdx = 3'(k);
      #1;
      chk($sformatf("R9 ccRdLo idx%0d", k), 32'(ccRdLo), 32'(expSt[posOf(3'(k))]));
      chk($sformatf("R9 ccRdHi idx%0d", k), 32'(ccRdHi), 32'(expSt[posOf(3'(k + 1))]));
    end

    // R10 inputs toggle without valid
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      predCode = 4'(k * 3); opA = {ONE, PZ}; opB = {ONE, PZ}; ccIdx = 3'(k);
      pairMode = k[0];
      @(negedge clk);
      chk("R10 no strobe no change", statusWord, expSt);
    end

    // R8 back-to-back strobes to codes 6 then 4
    @(negedge clk);
    cmpValid = 1'b1; predCode = 4'd6; opA = {JUNK, ONE}; opB = {JUNK, ONE}; ccIdx = 3'd6; pairMode = 1'b0;
    @(negedge clk);
    predCode = 4'd4; opA = {JUNK, ONE}; opB = {JUNK, TWO}; ccIdx = 3'd4;
    @(negedge clk);
    cmpValid = 1'b0;
    expSt[posOf(3'd6)] = 1'b1;
    chk("R8 first of pair committed", statusWord, expSt);
    @(negedge clk);
    expSt[posOf(3'd4)] = 1'b1;
    chk("R8 second of pair committed", statusWord, expSt);
    chk("R5 reserved bits stay zero", statusWord & 32'h007FFFFF, 32'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule